// File: doc/BRIEF.md
# Key-List Hash Message Packer

This block turns a list of 40-bit device keys and a 16-bit status field into the sequence of 32-bit words that a SHA-1 engine consumes when it checks a repeater's key list. Keys arrive one byte at a time and are packed back to back into big-endian words. Because a key is five bytes and a word is four, key bytes spill over from one word into the next. The tail that follows the keys holds the two status bytes and eight byte slots. The hash engine fills those slots with its own secret value. The layout of this tail depends on how many key bytes were left over in the last partly filled word.

Every output word carries a text-size tag: the number of bytes in the word that are message text. The engine treats the rest of the word as secret-value slots. After the tail the packer adds zero words until the byte offset within the 64-byte block reaches 60. It then appends the message length in bits and pulses a completion strobe. A flag marks each word that opens a new 64-byte block, so the engine can re-arm its full-text mode there. A request with a device count of zero is refused before any word is produced.

Top module: `key_hash_packer`

## Requirements
- R1: `startReq` is taken only while `busy` is low. If `devCount` is 0, `rejectPulse` is high for exactly the next cycle, no word is produced and `busy` stays low. A `startReq` while `busy` is high is ignored: the count and status in use are not replaced and no `rejectPulse` occurs.
- R2: The 5×N key bytes are packed continuously and big-endian. The first byte of the stream lands in bits 31:24 of the first word. Every key word has `wordText` = 4. `wordText` is the number of text bytes (0..4) and never exceeds 4.
- R3: A key word is offered as soon as its four bytes are filled. While `wordValid` is high and `wordReady` is low, `wordData` and `wordText` stay stable. Status bytes are taken as `statusWord[15:8]` first, then `statusWord[7:0]`.
- R4: With 0 leftover bytes the tail is three words: {16'h0, s0, s1} with tag 2, then 0 with tag 0, then 0 with tag 2.
- R5: With 1 leftover byte k the tail is {8'h0, k, s0, s1} with tag 3 (the 24 text bits right-aligned), then 0 with tag 0, then 0 with tag 1.
- R6: With 2 leftover bytes k0,k1 the tail is {k0, k1, s0, s1} with tag 4, then two zero words with tag 0.
- R7: With 3 leftover bytes k0,k1,k2 the tail is {k0, k1, k2, s0} with tag 4, then {24'h0, s1} with tag 1, then 0 with tag 0, then 0 with tag 3.
- R8: After the tail, zero words with tag 4 follow until the byte offset of the next word, modulo 64, equals 60.
- R9: The last word is (5N+10)×8 with tag 4. `hashDone` is high for exactly one cycle, in the cycle after that word is accepted, and `busy` is low in that cycle.
- R10: `blockStart` is high with exactly those offered words whose byte offset in the stream is a multiple of 64.
- R11: Any N from 1 to 2^DEV_W−1 (127 by default) produces the full stream, including key words that cross 64-byte boundaries.
- R12: `keyReady` and `wordValid` are never high together. Both are low while the block is idle, and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to pack a new list |
| devCount | input | DEV_W | Number of device keys N |
| statusWord | input | 16 | Status bytes, first byte in 15:8 |
| keyValid | input | 1 | Key byte available |
| keyByte | input | 8 | Key byte, keys in order, each key first byte first |
| keyReady | output | 1 | Packer accepts a key byte this cycle |
| wordValid | output | 1 | Output word offered |
| wordReady | input | 1 | Hash engine takes the offered word |
| wordData | output | 32 | Output word |
| wordText | output | 3 | Text bytes in the word (0..4) |
| blockStart | output | 1 | Offered word opens a 64-byte block |
| hashDone | output | 1 | One-cycle strobe after the length word |
| rejectPulse | output | 1 | One-cycle strobe for a zero-count request |
| busy | output | 1 | A list is being packed |

## Verification
The assertions check four things on every cycle. An offered word stays stable under backpressure. Key intake and word output never overlap. The idle state stays quiet. The completion and reject strobes last one cycle each, and each follows its cause. The bench alone can show the contents of the stream: the big-endian spill of key bytes across words, and the four tail layouts chosen by N mod 4. It also shows where the zero padding stops, the length value, the 64-byte block marks, and that a start request during a run is ignored. It does this by comparing every word against a model built from the requirements, under random stall patterns on both sides.

// File: rtl/pack_pkg.sv
package pack_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_KEYS,
    PH_TAIL,
    PH_PAD,
    PH_LEN
  } phase_t;

  typedef enum logic [1:0] {
    SEL_ACC,
    SEL_TAIL,
    SEL_ZERO,
    SEL_LEN
  } wordSel_t;

  typedef struct packed {
    logic       capture;
    logic       loadByte;
    logic       clearAcc;
    wordSel_t   wordSel;
    logic [1:0] tailStep;
    logic [1:0] leftover;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [31:0] data;
    logic [2:0]  text;
  } tailWord_t;

  // Tail layout chosen by the number of carried key bytes
  function automatic tailWord_t tailWord(input logic [1:0] left,
                                         input logic [1:0] step,
                                         input logic [31:0] acc,
                                         input logic [15:0] stat);
    tailWord_t w;
    w.data = '0;
    w.text = 3'd0;
    unique case (left)
      2'd0: begin
        if (step == 2'd0) begin w.data = {16'h0, stat}; w.text = 3'd2; end
        else if (step == 2'd2) w.text = 3'd2;
      end
      2'd1: begin
        if (step == 2'd0) begin w.data = {8'h0, acc[31:24], stat}; w.text = 3'd3; end
        else if (step == 2'd2) w.text = 3'd1;
      end
      2'd2: begin
        if (step == 2'd0) begin w.data = {acc[31:16], stat}; w.text = 3'd4; end
      end
      default: begin
        if (step == 2'd0) begin w.data = {acc[31:8], stat[15:8]}; w.text = 3'd4; end
        else if (step == 2'd1) begin w.data = {24'h0, stat[7:0]}; w.text = 3'd1; end
        else if (step == 2'd3) w.text = 3'd3;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pack_datapath.sv
module pack_datapath
  import pack_pkg::*;
#(
  parameter int DEV_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DEV_W-1:0]  devCount,
  input  logic [15:0]       statusWord,
  input  logic [7:0]        keyByte,
  output logic [2:0]        fill,
  output logic [31:0]       wordData,
  output logic [2:0]        wordText
);

  logic [31:0]      acc;
  logic [15:0]      statusReg;
  logic [DEV_W-1:0] countReg;
  logic [31:0]      lenVal;
  tailWord_t        tailW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      fill      <= '0;
      statusReg <= '0;
      countReg  <= '0;
    end else if (strobe.capture) begin
      acc       <= '0;
      fill      <= '0;
      statusReg <= statusWord;
      countReg  <= devCount;
    end else if (strobe.clearAcc) begin
      acc  <= '0;
      fill <= '0;
    end else if (strobe.loadByte) begin
      acc[(3 - fill[1:0]) * 8 +: 8] <= keyByte;
      fill <= fill + 3'd1;
    end
  end

  always_comb begin
    lenVal = (32'(countReg) * 32'd5 + 32'd10) * 32'd8;
    tailW  = tailWord(strobe.leftover, strobe.tailStep, acc, statusReg);
    unique case (strobe.wordSel)
      SEL_ACC:  begin wordData = acc;        wordText = 3'd4; end
      SEL_TAIL: begin wordData = tailW.data; wordText = tailW.text; end
      SEL_ZERO: begin wordData = '0;         wordText = 3'd4; end
      default:  begin wordData = lenVal;     wordText = 3'd4; end
    endcase
  end

endmodule

// File: rtl/pack_ctrl.sv
module pack_ctrl
  import pack_pkg::*;
#(
  parameter int DEV_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [DEV_W-1:0]  devCount,
  input  logic              keyValid,
  input  logic              wordReady,
  input  logic [2:0]        fill,
  output logic              keyReady,
  output logic              wordValid,
  output logic              blockStart,
  output logic              hashDone,
  output logic              rejectPulse,
  output logic              busy,
  output ctrlStrobe_t       strobe
);

  localparam int MAX_DEV  = (1 << DEV_W) - 1;
  localparam int KL_W     = $clog2(5 * MAX_DEV + 1);
  localparam int IDX_W    = $clog2(5 * MAX_DEV + 10 + 64) + 1;
  localparam logic [5:0] LEN_SLOT = 6'd60;

  phase_t           phase;
  logic [KL_W-1:0]  keysLeft;
  logic [IDX_W-1:0] byteIdx;
  logic [1:0]       step;
  logic [1:0]       left;
  logic             xfer;
  logic             tailLast;
  logic             padAtLen;

  always_comb begin
    padAtLen  = (byteIdx[5:0] == LEN_SLOT);
    wordValid = ((phase == PH_KEYS) && (fill == 3'd4)) ||
                (phase == PH_TAIL) ||
                ((phase == PH_PAD) && !padAtLen) ||
                (phase == PH_LEN);
    keyReady  = (phase == PH_KEYS) && (fill != 3'd4) && (keysLeft != '0);
    xfer      = wordValid && wordReady;
    tailLast  = (left == 2'd3) ? (step == 2'd3) : (step == 2'd2);
    blockStart = wordValid && (byteIdx[5:0] == 6'd0);
    busy      = (phase != PH_IDLE);

    strobe.capture  = (phase == PH_IDLE) && startReq && (devCount != '0);
    strobe.loadByte = keyReady && keyValid;
    strobe.clearAcc = (phase == PH_KEYS) && xfer;
    strobe.tailStep = step;
    strobe.leftover = left;
    unique case (phase)
      PH_TAIL: strobe.wordSel = SEL_TAIL;
      PH_PAD:  strobe.wordSel = SEL_ZERO;
      PH_LEN:  strobe.wordSel = SEL_LEN;
      default: strobe.wordSel = SEL_ACC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      keysLeft    <= '0;
      byteIdx     <= '0;
      step        <= '0;
      left        <= '0;
      hashDone    <= 1'b0;
      rejectPulse <= 1'b0;
    end else begin
      hashDone    <= 1'b0;
      rejectPulse <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (startReq) begin
            if (devCount == '0) begin
              rejectPulse <= 1'b1;
            end else begin
              phase    <= PH_KEYS;
              keysLeft <= KL_W'(devCount) * KL_W'(5);
              byteIdx  <= '0;
            end
          end
        end
        PH_KEYS: begin
          if (xfer) begin
            byteIdx <= byteIdx + IDX_W'(4);
          end else if (strobe.loadByte) begin
            keysLeft <= keysLeft - KL_W'(1);
          end else if ((fill != 3'd4) && (keysLeft == '0)) begin
            phase <= PH_TAIL;
            step  <= 2'd0;
            left  <= fill[1:0];
          end
        end
        PH_TAIL: begin
          if (xfer) begin
            byteIdx <= byteIdx + IDX_W'(4);
            step    <= step + 2'd1;
            if (tailLast) phase <= PH_PAD;
          end
        end
        PH_PAD: begin
          if (padAtLen) phase <= PH_LEN;
          else if (xfer) byteIdx <= byteIdx + IDX_W'(4);
        end
        default: begin
          if (xfer) begin
            phase    <= PH_IDLE;
            hashDone <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/key_hash_packer.sv
module key_hash_packer
  import pack_pkg::*;
#(
  parameter int DEV_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [DEV_W-1:0]  devCount,
  input  logic [15:0]       statusWord,
  input  logic              keyValid,
  input  logic [7:0]        keyByte,
  output logic              keyReady,
  output logic              wordValid,
  input  logic              wordReady,
  output logic [31:0]       wordData,
  output logic [2:0]        wordText,
  output logic              blockStart,
  output logic              hashDone,
  output logic              rejectPulse,
  output logic              busy
);

  ctrlStrobe_t strobe;
  logic [2:0]  fill;

  pack_ctrl #(.DEV_W(DEV_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .devCount    (devCount),
    .keyValid    (keyValid),
    .wordReady   (wordReady),
    .fill        (fill),
    .keyReady    (keyReady),
    .wordValid   (wordValid),
    .blockStart  (blockStart),
    .hashDone    (hashDone),
    .rejectPulse (rejectPulse),
    .busy        (busy),
    .strobe      (strobe)
  );

  pack_datapath #(.DEV_W(DEV_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .devCount   (devCount),
    .statusWord (statusWord),
    .keyByte    (keyByte),
    .fill       (fill),
    .wordData   (wordData),
    .wordText   (wordText)
  );

endmodule

// File: rtl/pack_chk.sv
module pack_chk #(
  parameter int DEV_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [DEV_W-1:0]  devCount,
  input logic              keyReady,
  input logic              wordValid,
  input logic              wordReady,
  input logic [31:0]       wordData,
  input logic [2:0]        wordText,
  input logic              blockStart,
  input logic              hashDone,
  input logic              rejectPulse,
  input logic              busy
);

  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !wordReady |=> wordValid && $stable(wordData) && $stable(wordText));

  // R12
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyReady |-> !wordValid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wordValid && !keyReady);

  // R9
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    hashDone |-> !busy && $past(wordValid && wordReady));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hashDone |=> !hashDone);

  // R1
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> !busy && $past(startReq && (devCount == '0) && !busy));

  // R2
  text_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordText <= 3'd4);

  // R10
  block_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |-> wordValid);

endmodule

bind key_hash_packer pack_chk #(.DEV_W(DEV_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .devCount    (devCount),
  .keyReady    (keyReady),
  .wordValid   (wordValid),
  .wordReady   (wordReady),
  .wordData    (wordData),
  .wordText    (wordText),
  .blockStart  (blockStart),
  .hashDone    (hashDone),
  .rejectPulse (rejectPulse),
  .busy        (busy)
);

// File: tb/key_hash_packer_tb.sv
module key_hash_packer_tb;

  localparam int DEV_W = 7;
  localparam int MAXW  = 256;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [DEV_W-1:0]  devCount = '0;
  logic [15:0]       statusWord = '0;
  logic              keyValid = 1'b0;
  logic [7:0]        keyByte = '0;
  logic              keyReady;
  logic              wordValid;
  logic              wordReady = 1'b0;
  logic [31:0]       wordData;
  logic [2:0]        wordText;
  logic              blockStart;
  logic              hashDone;
  logic              rejectPulse;
  logic              busy;

  int total = 0;
  int bad = 0;

  logic [7:0]  keyMem [0:634];
  logic [31:0] expD [0:MAXW-1];
  logic [2:0]  expT [0:MAXW-1];
  int          expR [0:MAXW-1];
  int          expN;

  always #10 clk = ~clk;

  key_hash_packer #(.DEV_W(DEV_W)) u_dut (.*);

  function automatic string reqName(input int r);
    case (r)
      2: return "R2";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic [2:0] t, input int r);
    expD[expN] = d;
    expT[expN] = t;
    expR[expN] = r;
    expN++;
  endtask

  // Model built from the requirements
  task automatic buildExpected(input int n, input logic [15:0] s);
    logic [31:0] w;
    int f;
    expN = 0;
    w = '0;
    f = 0;
    for (int b = 0; b < 5 * n; b++) begin
      w[(3 - f) * 8 +: 8] = keyMem[b];
      f++;
      if (f == 4) begin
        push(w, 3'd4, 2);
        w = '0;
        f = 0;
      end
    end
    case (f)
      0: begin push({16'h0, s}, 3'd2, 4); push(0, 3'd0, 4); push(0, 3'd2, 4); end
      1: begin push({8'h0, w[31:24], s}, 3'd3, 5); push(0, 3'd0, 5); push(0, 3'd1, 5); end
      2: begin push({w[31:16], s}, 3'd4, 6); push(0, 3'd0, 6); push(0, 3'd0, 6); end
      default: begin
        push({w[31:8], s[15:8]}, 3'd4, 7); push({24'h0, s[7:0]}, 3'd1, 7);
        push(0, 3'd0, 7); push(0, 3'd3, 7);
      end
    endcase
    while (((expN * 4) % 64) != 60) push(0, 3'd4, 8);
    push(32'((5 * n + 10) * 8), 3'd4, 9);
  endtask

  task automatic runCase(input int n, input logic [15:0] s, input int rdyPct,
                         input bit noisyStart);
    int kptr, widx, cyc, rejSeen;
    bit gotDone;
    for (int i = 0; i < 5 * n; i++) keyMem[i] = 8'($urandom);
    buildExpected(n, s);
    @(negedge clk);
    startReq = 1'b1;
    devCount = DEV_W'(n);
    statusWord = s;
    @(negedge clk);
    startReq = 1'b0;
    kptr = 0; widx = 0; cyc = 0; rejSeen = 0; gotDone = 1'b0;
    while (!gotDone && cyc < 20000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      keyValid  = (kptr < 5 * n) && (($urandom % 4) != 0);
      keyByte   = keyValid ? keyMem[kptr] : 8'h00;
      wordReady = int'($urandom % 100) < rdyPct;
      if (noisyStart && (widx + 3 <= expN)) begin
        startReq   = (($urandom % 6) == 0);
        devCount   = DEV_W'($urandom);
        statusWord = 16'($urandom);
      end else begin
        startReq = 1'b0;
      end
      #1;
      if (hashDone) gotDone = 1'b1;
      if (rejectPulse) rejSeen++;
      if (keyValid && keyReady) kptr++;
      if (wordValid && wordReady) begin
        if (widx < expN) begin
          check(wordData == expD[widx], reqName(expR[widx]), "word data", wordData, expD[widx]);
          check(wordText == expT[widx], reqName(expR[widx]), "text tag", wordText, expT[widx]);
          // R10 block marks at offsets that are multiples of 64
          check(blockStart == (((widx * 4) % 64) == 0), "R10", "block mark",
                blockStart, ((widx * 4) % 64) == 0);
        end
        widx++;
      end
    end
    startReq = 1'b0;
    keyValid = 1'b0;
    wordReady = 1'b0;
    check(gotDone, "R9", "completion strobe (watchdog)", gotDone, 1);
    check(widx == expN, "R9", "word count", widx, expN);
    // R11 all key bytes consumed
    check(kptr == 5 * n, "R11", "key bytes taken", kptr, 5 * n);
    // R1 starts during a run are ignored
    check(rejSeen == 0, "R1", "reject during run", rejSeen, 0);
    @(negedge clk);
    check(!busy && !hashDone, "R9", "idle after done", {busy, hashDone}, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    #5;
    @(negedge clk);
    // R12 reset state
    check(!busy && !wordValid && !keyReady && !hashDone && !rejectPulse, "R12",
          "reset outputs", {busy, wordValid, keyReady, hashDone, rejectPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 zero count rejected
    startReq = 1'b1;
    devCount = '0;
    @(negedge clk);
    startReq = 1'b0;
    #1;
    check(rejectPulse && !busy, "R1", "reject strobe", {rejectPulse, busy}, 2);
    @(negedge clk);
    #1;
    check(!rejectPulse && !wordValid && !keyReady && !busy, "R1", "reject one cycle, no words",
          {rejectPulse, wordValid, keyReady, busy}, 0);

    runCase(4, 16'hA55A, 100, 1'b0);   // R4
    runCase(1, 16'h1234, 100, 1'b0);   // R5
    runCase(2, 16'hBEEF, 60, 1'b0);    // R6
    runCase(3, 16'hC0DE, 60, 1'b0);    // R7
    runCase(12, 16'h0F0F, 50, 1'b1);   // R8 padding, R3 stalls
    runCase(127, 16'h8001, 70, 1'b1);  // R11 largest list
    for (int i = 0; i < 6; i++) begin
      runCase(1 + int'($urandom % 127), 16'($urandom), 30 + int'($urandom % 70), 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule